// File: doc/BRIEF.md
# I2C Hang Watchdog

This block watches an I2C controller for two kinds of hang and raises a flag for each. The first kind is a stuck bus: the filtered SCL level stays high or low for longer than a programmed limit. The second kind is a stalled state machine: either the clock-generation FSM or the main transfer FSM keeps the same state code for longer than its own limit. Each limit is a power of two in module clock cycles.

The controller's register file supplies the configuration fields. It holds each exponent field with a reset value of 16 (`HW_EXP_DEFAULT` in the package), and the line check enable resets to off. There are three raw flags. Each one is sticky until a one-cycle clear pulse on its bit. A masked status vector gives the raw flags ANDed with their enables. Recovery from a hang is left to the logic that reads the flags.

Top module: `i2c_hang_watch`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, all raw flags and all status bits are 0.
- R2: With `line_to_en` = 1 and exponent N, raw bit 0 is 1 after the clock edge at which SCL has been sampled at the same level for 2^N consecutive edges. This applies to a high level and to a low level. N = 0 fires on the first stable edge.
- R3: Any change of the sampled SCL level restarts the line run from zero. A line that toggles more often than every 2^N edges never sets bit 0.
- R4: While `line_to_en` = 0 the line run is held at zero and bit 0 is never set. After enabling, the count starts fresh from the next edge.
- R5: Raw bit 1 (clock FSM) and raw bit 2 (main FSM) are set after the edge at which that FSM's state code has been unchanged for 2^T consecutive edges, where T is that FSM's own exponent. Any change of the code restarts its run.
- R6: An FSM exponent above `MAX_FSM_EXP` (default 23) acts as `MAX_FSM_EXP`.
- R7: Each run sets its flag at most once. After it has fired, and even if it is cleared, the flag is not set again until the watched signal has changed and a new full run has elapsed.
- R8: A raw flag stays at 1 until a cycle in which its `int_clr` bit is 1 clears it. If a new timeout occurs in the same cycle as the clear, the flag stays at 1.
- R9: `int_st` equals `int_raw` AND `int_ena`, combinationally and per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Filtered SCL level |
| scl_fsm_state | input | ST_W | State code of the clock-generation FSM |
| main_fsm_state | input | ST_W | State code of the main transfer FSM |
| line_to_en | input | 1 | Enables the stuck-line check |
| line_to_exp | input | EXP_W | Line limit exponent N (limit 2^N cycles) |
| scl_fsm_to_exp | input | EXP_W | Clock FSM limit exponent |
| main_fsm_to_exp | input | EXP_W | Main FSM limit exponent |
| int_clr | input | 3 | Write-one-to-clear pulse per flag (bit 0 line, 1 clock FSM, 2 main FSM) |
| int_ena | input | 3 | Per-flag enable for the masked status |
| int_raw | output | 3 | Sticky raw flags |
| int_st | output | 3 | Masked status |

## Verification
The bench builds the block with `MAX_FSM_EXP` = 6. An FSM exponent of 31 is therefore capped at 64 cycles, so the clamp and its exact firing edge come within a short run rather than millions of cycles. The line check runs with exponents 0 and 3, which reaches both the single-edge boundary and full runs at each SCL level. A behavioural model tracks all three runs and is compared on every clock. Directed checks fix the exact edge at which each flag appears.

// File: rtl/hw_pkg.sv
package hw_pkg;

  // Width of every run counter; large enough for a 2^31 line limit.
  localparam int CNT_W = 32;
  // Number of hang sources: 0 line, 1 clock FSM, 2 main FSM.
  localparam int NUM_SRC = 3;
  localparam int SRC_LINE = 0;
  localparam int SRC_SFSM = 1;
  localparam int SRC_MFSM = 2;
  // Reset value the register file uses for every exponent field.
  localparam int HW_EXP_DEFAULT = 16;

  // Last run value before the limit: (2^min(exp, cap)) - 1.
  function automatic logic [CNT_W-1:0] run_last(input int unsigned exp_v,
                                                input int unsigned cap);
    int unsigned eff;
    eff = (exp_v > cap) ? cap : exp_v;
    return (CNT_W'(1) << eff) - CNT_W'(1);
  endfunction

endpackage

// File: rtl/hw_run_timer.sv
module hw_run_timer
  import hw_pkg::*;
#(
  parameter int SIG_W = 1,
  parameter logic [SIG_W-1:0] RST_SIG = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SIG_W-1:0] sig,
  input  logic [CNT_W-1:0] last,
  output logic             hit
);

  logic [SIG_W-1:0] prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fired_q;
  logic             changed;

  assign changed = (sig != prev_q);
  // The edge at which the run reaches last+1 stable samples.
  assign hit = en && !changed && !fired_q && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= RST_SIG;
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else begin
      prev_q <= sig;
      if (!en || changed) begin
        cnt_q   <= '0;
        fired_q <= 1'b0;
      end else if (hit) begin
        fired_q <= 1'b1;
      end else if (!fired_q) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R7: a run produces a single hit
  a_r7_one_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);

  // R4: a disabled timer leaves the next run fresh
  a_r4_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0) && !fired_q);

  // R3: a changed sample never counts as the hitting edge
  a_r3_change_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    changed |-> !hit);

endmodule

// File: rtl/hw_flag_bank.sv
module hw_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] ena,
  output logic [N-1:0] raw,
  output logic [N-1:0] st
);

  logic [N-1:0] raw_q;

  // A set in the same cycle as a clear wins, so no event is lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= (raw_q & ~clr) | set;
  end

  assign raw = raw_q;
  assign st  = raw_q & ena;

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R8: sticky until cleared
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      raw_q[i] && !clr[i] |=> raw_q[i]);
    // R8: a clear with no coincident event drops the flag
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr[i] && !set[i] |=> !raw_q[i]);
    // R8: an event always leaves the flag set
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> raw_q[i]);
  end

endmodule

// File: rtl/i2c_hang_watch.sv
module i2c_hang_watch
  import hw_pkg::*;
#(
  parameter int ST_W        = 3,
  parameter int EXP_W       = 5,
  parameter int MAX_FSM_EXP = 23
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic [ST_W-1:0]    scl_fsm_state,
  input  logic [ST_W-1:0]    main_fsm_state,
  input  logic               line_to_en,
  input  logic [EXP_W-1:0]   line_to_exp,
  input  logic [EXP_W-1:0]   scl_fsm_to_exp,
  input  logic [EXP_W-1:0]   main_fsm_to_exp,
  input  logic [NUM_SRC-1:0] int_clr,
  input  logic [NUM_SRC-1:0] int_ena,
  output logic [NUM_SRC-1:0] int_raw,
  output logic [NUM_SRC-1:0] int_st
);

  localparam int unsigned LINE_CAP = CNT_W - 1;
  localparam int unsigned FSM_CAP  = (MAX_FSM_EXP < CNT_W) ? MAX_FSM_EXP : CNT_W - 1;

  logic [CNT_W-1:0]   line_last, sfsm_last, mfsm_last;
  logic               line_hit, sfsm_hit, mfsm_hit;
  logic [NUM_SRC-1:0] hit_vec;

  assign line_last = run_last(32'(line_to_exp), LINE_CAP);
  assign sfsm_last = run_last(32'(scl_fsm_to_exp), FSM_CAP);
  assign mfsm_last = run_last(32'(main_fsm_to_exp), FSM_CAP);

  hw_run_timer #(.SIG_W(1), .RST_SIG(1'b1)) u_line (
    .clk(clk), .rst_n(rst_n), .en(line_to_en), .sig(scl_in),
    .last(line_last), .hit(line_hit)
  );

  hw_run_timer #(.SIG_W(ST_W), .RST_SIG('0)) u_sfsm (
    .clk(clk), .rst_n(rst_n), .en(1'b1), .sig(scl_fsm_state),
    .last(sfsm_last), .hit(sfsm_hit)
  );

  hw_run_timer #(.SIG_W(ST_W), .RST_SIG('0)) u_mfsm (
    .clk(clk), .rst_n(rst_n), .en(1'b1), .sig(main_fsm_state),
    .last(mfsm_last), .hit(mfsm_hit)
  );

  always_comb begin
    hit_vec = '0;
    hit_vec[SRC_LINE] = line_hit;
    hit_vec[SRC_SFSM] = sfsm_hit;
    hit_vec[SRC_MFSM] = mfsm_hit;
  end

  hw_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(hit_vec), .clr(int_clr),
    .ena(int_ena), .raw(int_raw), .st(int_st)
  );

  // R9: status never shows a flag that is not raised
  a_r9_status_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (int_st & ~int_raw) == '0);

  // R4: a disabled line check never raises its flag
  a_r4_line_off: assert property (@(posedge clk) disable iff (!rst_n)
    !line_to_en && !int_raw[SRC_LINE] && !int_clr[SRC_LINE] |=> !int_raw[SRC_LINE]);

endmodule

// File: tb/i2c_hang_watch_test.sv
module i2c_hang_watch_test;

  localparam int ST_W = 3;
  localparam int CAP  = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, scl, l_en;
  logic [ST_W-1:0] sst, mst;
  logic [4:0] l_exp, s_exp, m_exp;
  logic [2:0] clr, ena;
  wire  [2:0] raw, st;

  i2c_hang_watch #(.ST_W(ST_W), .EXP_W(5), .MAX_FSM_EXP(CAP)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .scl_fsm_state(sst),
    .main_fsm_state(mst), .line_to_en(l_en), .line_to_exp(l_exp),
    .scl_fsm_to_exp(s_exp), .main_fsm_to_exp(m_exp), .int_clr(clr),
    .int_ena(ena), .int_raw(raw), .int_st(st)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string cur_req = "R1";

  // Behavioural reference model
  longint l_run, s_run, m_run;
  bit l_done, s_done, m_done;
  logic m_scl_prev;
  logic [ST_W-1:0] m_s_prev, m_m_prev;
  logic [2:0] exp_raw, set_v;

  function automatic longint lim(input int e, input int cap);
    int x;
    x = (e > cap) ? cap : e;
    return longint'(1) << x;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      l_run = 0; s_run = 0; m_run = 0;
      l_done = 0; s_done = 0; m_done = 0;
      m_scl_prev = 1'b1; m_s_prev = '0; m_m_prev = '0;
      exp_raw = '0;
    end else begin
      set_v = '0;
      if (!l_en || scl !== m_scl_prev) begin l_run = 0; l_done = 0; end
      else if (!l_done) begin
        l_run++;
        if (l_run == lim(int'(l_exp), 31)) begin l_done = 1; set_v[0] = 1'b1; end
      end
      m_scl_prev = scl;
      if (sst !== m_s_prev) begin s_run = 0; s_done = 0; end
      else if (!s_done) begin
        s_run++;
        if (s_run == lim(int'(s_exp), CAP)) begin s_done = 1; set_v[1] = 1'b1; end
      end
      m_s_prev = sst;
      if (mst !== m_m_prev) begin m_run = 0; m_done = 0; end
      else if (!m_done) begin
        m_run++;
        if (m_run == lim(int'(m_exp), CAP)) begin m_done = 1; set_v[2] = 1'b1; end
      end
      m_m_prev = mst;
      exp_raw = (exp_raw & ~clr) | set_v;
    end
  end

  // Per-cycle comparison against the model
  always @(posedge clk) begin
    #3;
    if (rst_n && !finished) begin
      total++;
      if (raw !== exp_raw || st !== (exp_raw & ena)) begin
        bad++;
        $display("FAIL %s model: raw=%b st=%b expected raw=%b st=%b",
                 cur_req, raw, st, exp_raw, exp_raw & ena);
      end
    end
  end

  task automatic chk(input string req, input logic [2:0] got, input logic [2:0] want);
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s got %b expected %b", req, got, want);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic put_clr(input logic [2:0] m);
    @(negedge clk) clr = m;
    @(negedge clk) clr = '0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired got running expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; scl = 1'b1; l_en = 1'b0; sst = '0; mst = '0;
    l_exp = 5'd3; s_exp = 5'd31; m_exp = 5'd31; clr = '0; ena = 3'b111;
    repeat (3) @(negedge clk);
    chk("R1 raw in reset", raw, 3'b000);
    chk("R1 st in reset", st, 3'b000);
    @(negedge clk) rst_n = 1'b1;
    edges(1);
    chk("R1 raw after release", raw, 3'b000);

    // R2: low level stuck
    cur_req = "R2";
    @(negedge clk) begin l_en = 1'b1; scl = 1'b0; end
    edges(8);  chk("R2 low before limit", {2'b0, raw[0]}, 3'b000);
    edges(1);  chk("R2 low at limit", {2'b0, raw[0]}, 3'b001);

    // R8 clear, then R7 no refire
    cur_req = "R7";
    put_clr(3'b001);
    edges(1);  chk("R8 cleared", {2'b0, raw[0]}, 3'b000);
    edges(20); chk("R7 no refire while stuck", {2'b0, raw[0]}, 3'b000);

    // R2: high level stuck
    cur_req = "R2";
    @(negedge clk) scl = 1'b1;
    edges(8);  chk("R2 high before limit", {2'b0, raw[0]}, 3'b000);
    edges(1);  chk("R2 high at limit", {2'b0, raw[0]}, 3'b001);

    // R3: toggling line never fires
    cur_req = "R3";
    put_clr(3'b001);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) scl = ~scl;
      repeat (4) @(negedge clk);
    end
    edges(1);  chk("R3 toggling line", {2'b0, raw[0]}, 3'b000);

    // R4: disabled line check
    cur_req = "R4";
    @(negedge clk) l_en = 1'b0;
    edges(40); chk("R4 disabled", {2'b0, raw[0]}, 3'b000);
    @(negedge clk) l_en = 1'b1;
    edges(7);  chk("R4 fresh run before limit", {2'b0, raw[0]}, 3'b000);
    edges(1);  chk("R4 fresh run at limit", {2'b0, raw[0]}, 3'b001);

    // R2: exponent zero
    cur_req = "R2";
    put_clr(3'b001);
    @(negedge clk) begin l_exp = 5'd0; scl = ~scl; end
    edges(1);  chk("R2 exp0 change edge", {2'b0, raw[0]}, 3'b000);
    edges(1);  chk("R2 exp0 first stable", {2'b0, raw[0]}, 3'b001);

    // R8: set and clear together
    cur_req = "R8";
    @(negedge clk) l_exp = 5'd3;
    put_clr(3'b001);
    @(negedge clk) scl = ~scl;
    repeat (8) @(negedge clk);
    clr = 3'b001;
    @(negedge clk) clr = '0;
    chk("R8 set wins over clear", {2'b0, raw[0]}, 3'b001);
    edges(1);  chk("R8 stays sticky", {2'b0, raw[0]}, 3'b001);
    put_clr(3'b001);
    edges(1);  chk("R8 clear pulse", {2'b0, raw[0]}, 3'b000);

    // R5: main FSM
    cur_req = "R5";
    @(negedge clk) begin l_en = 1'b0; m_exp = 5'd2; mst = mst + 1'b1; end
    put_clr(3'b110);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk) mst = mst + 1'b1;
      repeat (2) @(negedge clk);
    end
    edges(1);  chk("R5 main FSM moving", {raw[2], 2'b0}, 3'b000);
    @(negedge clk) mst = mst + 1'b1;
    edges(4);  chk("R5 main FSM before limit", {raw[2], 2'b0}, 3'b000);
    edges(1);  chk("R5 main FSM at limit", {raw[2], 2'b0}, 3'b100);

    // R5: clock FSM
    @(negedge clk) begin s_exp = 5'd3; sst = sst + 1'b1; end
    put_clr(3'b010);
    edges(6);  chk("R5 clock FSM before limit", {1'b0, raw[1], 1'b0}, 3'b000);
    edges(1);  chk("R5 clock FSM at limit", {1'b0, raw[1], 1'b0}, 3'b010);

    // R6: exponent above cap
    cur_req = "R6";
    @(negedge clk) begin s_exp = 5'd31; sst = sst + 1'b1; end
    put_clr(3'b010);
    edges(62); chk("R6 capped before limit", {1'b0, raw[1], 1'b0}, 3'b000);
    edges(1);  chk("R6 capped at limit", {1'b0, raw[1], 1'b0}, 3'b010);

    // R9: masked status
    cur_req = "R9";
    @(negedge clk) ena = 3'b000;
    edges(1);  chk("R9 all masked", st, 3'b000);
    @(negedge clk) ena = 3'b010;
    edges(1);  chk("R9 one enabled", st, exp_raw & 3'b010);
    chk("R9 clock FSM visible", {1'b0, st[1], 1'b0}, 3'b010);
    @(negedge clk) ena = 3'b101;
    edges(1);  chk("R9 other bits", st, exp_raw & 3'b101);

    edges(5);
    finish_run();
  end

endmodule